// File: doc/BRIEF.md
# Handshake Word Crossing Between Clock Domains

This block carries one multi-bit word at a time from a source clock domain into an unrelated destination clock domain. A request/acknowledge pair of control bits is the only thing that passes through synchronising flip-flop chains. The word itself sits in a source-side holding register. That register does not change while a transfer is open. Because of this, the destination can sample the bus directly at the moment it sees the request arrive, and every bit of the word is taken in a single cycle. Synchronising each bit on its own could let the bits resolve in different cycles and mix two words; this design avoids that.

A parameter chooses the protocol. With `TWO_PHASE = 0` the request and acknowledge each rise and then fall again for every word (return-to-zero). With `TWO_PHASE = 1` every word costs exactly one toggle of the request and one toggle of the acknowledge. The source side sees a busy flag and a one-cycle send strobe. The destination side sees the word and a one-cycle valid pulse. The block suits occasional, slow transfers such as configuration words or status snapshots.

Top module: `cdc_word_handshake`

## Requirements
- R1: While both resets are asserted, and on the first cycles after they are released, `src_busy` is low, `dst_valid` is low and `dst_data` is zero.
- R2: A `src_send` sampled high while `src_busy` is low is accepted. `src_busy` is high from the next source clock edge, and the word on `src_data` at that edge is the word delivered.
- R3: The source holding register keeps the accepted word unchanged for as long as `src_busy` stays high.
- R4: A `src_send` sampled while `src_busy` is high is ignored. It neither changes the word in flight nor creates an extra delivery.
- R5: Every accepted word appears on `dst_data` exactly once, in the order accepted, with `dst_valid` high in that cycle.
- R6: `dst_valid` is never high in two consecutive destination cycles. `dst_data` changes only in a cycle where `dst_valid` is high.
- R7: In four-phase mode (`TWO_PHASE = 0`), request and acknowledge both return low before `src_busy` clears. Whenever the source is idle, both are low.
- R8: In two-phase mode (`TWO_PHASE = 1`), each word uses one toggle of the request and one toggle of the acknowledge. Whenever the source is idle, the two levels are equal.
- R9: Only the request and acknowledge pass through `SYNC_STAGES` flip-flop synchronisers. The word is captured from the holding register without per-bit synchronisers, and it arrives intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous |
| src_data | input | DATA_W | Word offered for transfer |
| src_send | input | 1 | One-cycle strobe asking to send `src_data` |
| src_busy | output | 1 | High while a transfer is open; sends are ignored then |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous |
| dst_data | output | DATA_W | Last delivered word |
| dst_valid | output | 1 | One-cycle pulse marking a newly delivered word |

## Verification
The assertions assume that both resets are asserted and released together. They also assume that the two clocks run freely, so that each synchroniser eventually passes a stable level. The stimulus holds the resets jointly and drives the source clock at 8 ns and the destination clock at an unrelated 13 ns. It changes inputs only on falling source edges. It deliberately raises `src_send` again while a transfer is open, with a different word on the bus, so that the ignore path is exercised without breaking those assumptions.

// File: rtl/cdc_hs_pkg.sv
package cdc_hs_pkg;

   // Source-side phases of a return-to-zero exchange
   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_WAIT  = 2'd1,
      SRC_DRAIN = 2'd2
   } src_phase_t;

   // Smallest synchroniser depth accepted by the library
   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_src.sv
module hs_src
   import cdc_hs_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter bit          TWO_PHASE   = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] data_in,
   input  logic              send,
   input  logic              ack_async,
   output logic              req,
   output logic [DATA_W-1:0] hold,
   output logic              busy
);
   logic ack_s;
   logic take;

   hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ack_async),
      .q    (ack_s)
   );

   assign take = send && !busy;

   // Holding register: loads only when a send is accepted
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold <= '0;
      else if (take) hold <= data_in;
   end

   if (TWO_PHASE) begin : g_toggle
      logic req_t;
      logic open_t;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_t  <= 1'b0;
            open_t <= 1'b0;
         end else if (take) begin
            req_t  <= ~req_t;
            open_t <= 1'b1;
         end else if (open_t && (ack_s == req_t)) begin
            open_t <= 1'b0;
         end
      end

      assign req  = req_t;
      assign busy = open_t;
   end else begin : g_rtz
      src_phase_t phase;
      logic       req_l;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase <= SRC_IDLE;
            req_l <= 1'b0;
         end else begin
            unique case (phase)
               SRC_IDLE: if (take) begin
                  req_l <= 1'b1;
                  phase <= SRC_WAIT;
               end
               SRC_WAIT: if (ack_s) begin
                  req_l <= 1'b0;
                  phase <= SRC_DRAIN;
               end
               SRC_DRAIN: if (!ack_s) phase <= SRC_IDLE;
               default: begin
                  req_l <= 1'b0;
                  phase <= SRC_IDLE;
               end
            endcase
         end
      end

      assign req  = req_l;
      assign busy = (phase != SRC_IDLE);
   end
endmodule

// File: rtl/hs_dst.sv
module hs_dst #(
   parameter int unsigned DATA_W      = 16,
   parameter bit          TWO_PHASE   = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_async,
   input  logic [DATA_W-1:0] bus,
   output logic              ack,
   output logic [DATA_W-1:0] data_out,
   output logic              valid
);
   logic req_s;
   logic grab;

   hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (req_async),
      .q    (req_s)
   );

   if (TWO_PHASE) begin : g_toggle
      assign grab = (req_s != ack);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    ack <= 1'b0;
         else if (grab) ack <= req_s;
      end
   end else begin : g_rtz
      assign grab = req_s && !ack;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             ack <= 1'b0;
         else if (grab)          ack <= 1'b1;
         else if (!req_s && ack) ack <= 1'b0;
      end
   end

   // Word is sampled straight from the stable source holding register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_out <= '0;
         valid    <= 1'b0;
      end else begin
         valid <= grab;
         if (grab) data_out <= bus;
      end
   end
endmodule

// File: rtl/cdc_word_handshake.sv
module cdc_word_handshake
   import cdc_hs_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter bit          TWO_PHASE   = 1'b0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              src_clk,
   input  logic              src_rst_n,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_send,
   output logic              src_busy,
   input  logic              dst_clk,
   input  logic              dst_rst_n,
   output logic [DATA_W-1:0] dst_data,
   output logic              dst_valid
);
   if (DATA_W < 1) begin : g_bad_width
      $error("cdc_word_handshake: DATA_W must be at least 1");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
      $error("cdc_word_handshake: SYNC_STAGES below minimum");
   end

   logic              req_w;
   logic              ack_w;
   logic [DATA_W-1:0] hold_w;

   hs_src #(
      .DATA_W     (DATA_W),
      .TWO_PHASE  (TWO_PHASE),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_src (
      .clk      (src_clk),
      .rst_n    (src_rst_n),
      .data_in  (src_data),
      .send     (src_send),
      .ack_async(ack_w),
      .req      (req_w),
      .hold     (hold_w),
      .busy     (src_busy)
   );

   hs_dst #(
      .DATA_W     (DATA_W),
      .TWO_PHASE  (TWO_PHASE),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_dst (
      .clk      (dst_clk),
      .rst_n    (dst_rst_n),
      .req_async(req_w),
      .bus      (hold_w),
      .ack      (ack_w),
      .data_out (dst_data),
      .valid    (dst_valid)
   );
endmodule

// File: rtl/cdc_hs_checker.sv
module cdc_hs_checker #(
   parameter int unsigned DATA_W    = 16,
   parameter bit          TWO_PHASE = 1'b0
) (
   input logic              src_clk,
   input logic              src_rst_n,
   input logic              dst_clk,
   input logic              dst_rst_n,
   input logic              src_send,
   input logic              src_busy,
   input logic              dst_valid,
   input logic [DATA_W-1:0] dst_data,
   input logic [DATA_W-1:0] hold,
   input logic              req,
   input logic              ack
);
   // R2: an accepted send opens a transfer on the next edge
   a_r2_send_opens: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (src_send && !src_busy) |=> src_busy);

   // R3: the word in flight does not move while busy
   a_r3_hold_stable: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (src_busy && $past(src_busy)) |-> $stable(hold));

   // R6: valid is a single-cycle pulse
   a_r6_valid_single: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      dst_valid |=> !dst_valid);

   // R6: output word only changes alongside a valid pulse
   a_r6_data_quiet: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      !dst_valid |-> $stable(dst_data));

   if (TWO_PHASE) begin : g_toggle
      // R8: idle source means request and acknowledge levels agree
      a_r8_idle_levels_equal: assert property (@(posedge src_clk) disable iff (!src_rst_n)
         !src_busy |-> (req == ack));
   end else begin : g_rtz
      // R7: idle source means both control lines have returned low
      a_r7_idle_quiet: assert property (@(posedge src_clk) disable iff (!src_rst_n)
         !src_busy |-> (!req && !ack));
   end
endmodule

bind cdc_word_handshake cdc_hs_checker #(
   .DATA_W   (DATA_W),
   .TWO_PHASE(TWO_PHASE)
) u_chk (
   .src_clk  (src_clk),
   .src_rst_n(src_rst_n),
   .dst_clk  (dst_clk),
   .dst_rst_n(dst_rst_n),
   .src_send (src_send),
   .src_busy (src_busy),
   .dst_valid(dst_valid),
   .dst_data (dst_data),
   .hold     (hold_w),
   .req      (req_w),
   .ack      (ack_w)
);

// File: tb/cdc_word_handshake_bench.sv
module cdc_word_handshake_bench;
   localparam int W     = 8;
   localparam int NWORD = 40;

   logic src_clk = 1'b0;
   logic dst_clk = 1'b0;
   logic src_rst_n = 1'b0;
   logic dst_rst_n = 1'b0;

   always #4   src_clk = ~src_clk;   // 125 MHz
   always #6.5 dst_clk = ~dst_clk;   // unrelated destination clock

   logic [W-1:0] sdata [2];
   logic         send  [2];
   logic         busy  [2];
   logic [W-1:0] rdata [2];
   logic         valid [2];

   int tests = 0;
   int fails = 0;
   int rcv   [2];
   logic prev_v [2];

   // index 0: four-phase, index 1: two-phase
   cdc_word_handshake #(.DATA_W(W), .TWO_PHASE(1'b0), .SYNC_STAGES(2)) u_cdc_word_handshake (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .src_data(sdata[0]), .src_send(send[0]),
      .src_busy(busy[0]), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
      .dst_data(rdata[0]), .dst_valid(valid[0]));

   cdc_word_handshake #(.DATA_W(W), .TWO_PHASE(1'b1), .SYNC_STAGES(2)) u_cdc_word_handshake_2p (
      .src_clk(src_clk), .src_rst_n(src_rst_n), .src_data(sdata[1]), .src_send(send[1]),
      .src_busy(busy[1]), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
      .dst_data(rdata[1]), .dst_valid(valid[1]));

   function automatic logic [W-1:0] exp_word(input int m, input int i);
      if (i == 0) return 8'h00;
      if (i == 1) return 8'hFF;
      return W'((i * 37 + 5 + m * 91) & 255);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Destination monitor: order, exactly-once, pulse width
   always @(negedge dst_clk) begin
      for (int m = 0; m < 2; m++) begin
         if (dst_rst_n && valid[m]) begin
            // R5 R9: word intact and in order
            check(rdata[m] === exp_word(m, rcv[m]), (m == 0) ? "R5 R9 R7 word" : "R5 R9 R8 word",
                  int'(rdata[m]), int'(exp_word(m, rcv[m])));
            // R6: no back-to-back valid
            check(!prev_v[m], "R6 single pulse", int'(prev_v[m]), 0);
            rcv[m]++;
         end
         prev_v[m] = valid[m];
      end
   end

   task automatic send_word(input int m, input logic [W-1:0] d, input bit poke);
      while (busy[m] !== 1'b0) @(negedge src_clk);
      sdata[m] = d;
      send[m]  = 1'b1;
      @(negedge src_clk);
      send[m]  = 1'b0;
      check(busy[m] === 1'b1, "R2 busy after send", int'(busy[m]), 1);
      if (poke) begin
         // R4: different word offered while busy must be dropped
         sdata[m] = ~d;
         send[m]  = 1'b1;
         @(negedge src_clk);
         send[m]  = 1'b0;
         check(busy[m] === 1'b1, "R4 still busy", int'(busy[m]), 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge src_clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int m = 0; m < 2; m++) begin
         sdata[m]  = '0;
         send[m]   = 1'b0;
         rcv[m]    = 0;
         prev_v[m] = 1'b0;
      end
      repeat (5) @(negedge src_clk);
      for (int m = 0; m < 2; m++) begin
         check(busy[m] === 1'b0, "R1 busy in reset", int'(busy[m]), 0);
         check(valid[m] === 1'b0, "R1 valid in reset", int'(valid[m]), 0);
      end
      src_rst_n = 1'b1;
      dst_rst_n = 1'b1;
      repeat (3) @(negedge src_clk);
      for (int m = 0; m < 2; m++) begin
         check(busy[m] === 1'b0, "R1 busy after reset", int'(busy[m]), 0);
         check(rdata[m] === '0, "R1 data after reset", int'(rdata[m]), 0);
      end

      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < NWORD; i++) send_word(m, exp_word(m, i), (i % 5) == 2);
         repeat (80) @(negedge src_clk);
         check(busy[m] === 1'b0, (m == 0) ? "R7 idle at end" : "R8 idle at end", int'(busy[m]), 0);
         check(rcv[m] == NWORD, "R5 R4 delivery count", rcv[m], NWORD);
         // R6: last word still presented after pulse
         check(rdata[m] === exp_word(m, NWORD - 1), "R6 data held", int'(rdata[m]),
               int'(exp_word(m, NWORD - 1)));
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule